// File: doc/BRIEF.md
# Compression Threshold Detector With Hysteresis

This block decides, sample by sample, whether a dynamic range compressor downstream should be compressing. Each incoming audio sample passes through a host-programmable first-order high-pass IIR stage and then a host-programmable first-order low-pass IIR stage. The magnitude of the low-pass result is converted to a level in whole decibels relative to full scale. That level is compared with a selectable threshold, and the comparison uses a hysteresis window.

The block produces three outputs. The first is a compression-active state. The second is a live over-threshold flag that follows each decision. The third is a sticky copy of that flag, which holds until the host pulses a read strobe. A global enable turns the detector off. Computing the gain reduction belongs to a later stage.

Top module: `drc_level_detector`

## Requirements
- R1: After reset, comp_active, over_live and over_sticky are all 0.
- R2: Each filter stage computes y = sat(floor((c0*x + c1*x_prev + fb*y_prev) / 2^15)) on every sample it receives. All coefficients are 16-bit two's complement in 1.15 format. Saturation limits y to -32768..32767. The high-pass stage takes smp_in. The low-pass stage takes the high-pass output.
- R3: The level of low-pass output y is computed from m = |y|. Let p be the index of the highest set bit of m. Let f be the three bits that follow that bit, with zero fill below bit 0. The level is 6*p + T[f] - 90 dB, with T = {0,1,2,3,4,4,5,5} for f = 0..7. When m = 0 the level is -96 dB.
- R4: The threshold in dB is -3*(thr_code+1). Code 0 gives -3 dB and code 7 gives -24 dB.
- R5: While comp_active is 0, it becomes 1 only when level > threshold + hyst_code, where hyst_code is in dB.
- R6: While comp_active is 1, it becomes 0 only when level < threshold - hyst_code. Inside the window it holds. With hyst_code 0, a level equal to the threshold holds the current state.
- R7: At each decision, over_live takes the value of (level > threshold).
- R8: A decision with level > threshold sets over_sticky. A flag_rd pulse clears it. When a read and a setting decision fall on the same edge, over_sticky stays 1.
- R9: A decision taken while det_en is 0 forces comp_active and over_live to 0 and does not set over_sticky.
- R10: A sample strobed on one rising edge changes the outputs on the third rising edge. At all other edges comp_active and over_live hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample |
| smp_in | input | 16 | Signed audio sample |
| hp_c0 | input | 16 | High-pass current-input coefficient |
| hp_c1 | input | 16 | High-pass previous-input coefficient |
| hp_fb | input | 16 | High-pass feedback coefficient |
| lp_c0 | input | 16 | Low-pass current-input coefficient |
| lp_c1 | input | 16 | Low-pass previous-input coefficient |
| lp_fb | input | 16 | Low-pass feedback coefficient |
| det_en | input | 1 | Detector enable |
| thr_code | input | 3 | Threshold select |
| hyst_code | input | 2 | Hysteresis width in dB |
| flag_rd | input | 1 | Host read pulse that clears the sticky flag |
| comp_active | output | 1 | Compression-active state |
| over_live | output | 1 | Non-sticky over-threshold flag |
| over_sticky | output | 1 | Sticky over-threshold flag |

## Verification
A host read of the sticky flag can land on the same edge as a decision that sets it, and these two must not cancel. The bench places the flag_rd pulse exactly on the decision edge of a sample whose level is above threshold, and again on the decision edge of a sample below threshold. It expects the flag to stay 1 in the first case and to clear in the second. Every threshold and hysteresis code pair is swept with rising and falling 1 dB amplitude ramps. Each decision is compared against a bench model that computes the filter arithmetic and the level with real-valued logarithms.

// File: rtl/drc_det_pkg.sv
package drc_det_pkg;
   localparam int MANT_BITS = 3;
   localparam int DB_PER_OCTAVE = 6;

   // rounded 20*log10(1 + f/8)
   function automatic int mant_db(input logic [MANT_BITS-1:0] f);
      case (f)
         3'd0:       return 0;
         3'd1:       return 1;
         3'd2:       return 2;
         3'd3:       return 3;
         3'd4, 3'd5: return 4;
         default:    return 5;
      endcase
   endfunction
endpackage

// File: rtl/drc_iir1.sv
module drc_iir1 #(
   parameter int W  = 16,
   parameter int CW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step,
   input  logic signed [W-1:0]  x,
   input  logic signed [CW-1:0] c_cur,
   input  logic signed [CW-1:0] c_prev,
   input  logic signed [CW-1:0] c_fb,
   output logic signed [W-1:0]  y
);
   localparam int PW   = W + CW;
   localparam int AW   = PW + 2;
   localparam int FRAC = CW - 1;
   localparam logic signed [AW-1:0] YMAX = AW'((64'sd1 <<< (W-1)) - 64'sd1);
   localparam logic signed [AW-1:0] YMIN = -YMAX - AW'(1);

   logic signed [W-1:0]  x_prev;
   logic signed [PW-1:0] p_cur, p_prev, p_fb;
   logic signed [AW-1:0] acc, shf;
   logic signed [W-1:0]  y_next;

   always_comb begin
      p_cur  = x * c_cur;
      p_prev = x_prev * c_prev;
      p_fb   = y * c_fb;
      acc    = AW'(p_cur) + AW'(p_prev) + AW'(p_fb);
      shf    = acc >>> FRAC;
      if (shf > YMAX)      y_next = YMAX[W-1:0];
      else if (shf < YMIN) y_next = YMIN[W-1:0];
      else                 y_next = shf[W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_prev <= '0;
         y      <= '0;
      end else if (step) begin
         x_prev <= x;
         y      <= y_next;
      end
   end
endmodule

// File: rtl/drc_log_level.sv
module drc_log_level
   import drc_det_pkg::*;
#(
   parameter int W   = 16,
   parameter int LVW = 9
) (
   input  logic signed [W-1:0]   val,
   output logic signed [LVW-1:0] level
);
   localparam int FS_DB    = DB_PER_OCTAVE * (W - 1);
   localparam int FLOOR_DB = -DB_PER_OCTAVE * W;

   logic [W-1:0]           mag, norm;
   logic [MANT_BITS-1:0]   frac;
   int                     msb;
   int                     lvl;

   always_comb begin
      mag = val[W-1] ? (~val + W'(1)) : val;
      msb = 0;
      for (int i = 0; i < W; i++) begin
         if (mag[i]) msb = i;
      end
      norm = mag << (W - 1 - msb);
      frac = norm[W-2 -: MANT_BITS];
      if (mag == '0) lvl = FLOOR_DB;
      else           lvl = DB_PER_OCTAVE * msb + mant_db(frac) - FS_DB;
      level = LVW'(lvl);
   end
endmodule

// File: rtl/drc_hyst_decide.sv
module drc_hyst_decide #(
   parameter int TW      = 3,
   parameter int HW      = 2,
   parameter int LVW     = 9,
   parameter int STEP_DB = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  upd,
   input  logic                  en,
   input  logic signed [LVW-1:0] level,
   input  logic [TW-1:0]         thr_code,
   input  logic [HW-1:0]         hyst_code,
   input  logic                  rd,
   output logic                  active,
   output logic                  live,
   output logic                  sticky
);
   int  lv, thr, on_lim, off_lim;
   logic over, set_now;

   always_comb begin
      lv      = int'(level);
      thr     = -(int'(thr_code) + 1) * STEP_DB;
      on_lim  = thr + int'(hyst_code);
      off_lim = thr - int'(hyst_code);
      over    = lv > thr;
      set_now = upd & en & over;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         live   <= 1'b0;
      end else if (upd) begin
         if (!en) begin
            active <= 1'b0;
            live   <= 1'b0;
         end else begin
            live <= over;
            if (active) begin
               if (lv < off_lim) active <= 1'b0;
            end else if (lv > on_lim) begin
               active <= 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky <= 1'b0;
      else        sticky <= set_now | (sticky & ~rd);
   end
endmodule

// File: rtl/drc_level_detector.sv
module drc_level_detector #(
   parameter int W       = 16,
   parameter int CW      = 16,
   parameter int TW      = 3,
   parameter int HW      = 2,
   parameter int STEP_DB = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_vld,
   input  logic signed [W-1:0]  smp_in,
   input  logic signed [CW-1:0] hp_c0,
   input  logic signed [CW-1:0] hp_c1,
   input  logic signed [CW-1:0] hp_fb,
   input  logic signed [CW-1:0] lp_c0,
   input  logic signed [CW-1:0] lp_c1,
   input  logic signed [CW-1:0] lp_fb,
   input  logic                 det_en,
   input  logic [TW-1:0]        thr_code,
   input  logic [HW-1:0]        hyst_code,
   input  logic                 flag_rd,
   output logic                 comp_active,
   output logic                 over_live,
   output logic                 over_sticky
);
   localparam int NSTG = 2;
   localparam int LVW  = $clog2(6 * W + 1) + 2;

   if (W < 8 || W > 24) begin : g_bad_w
      $error("drc_level_detector: W out of range");
   end
   if (CW < 4 || CW > 24) begin : g_bad_cw
      $error("drc_level_detector: CW out of range");
   end
   if (TW < 1 || HW < 1 || STEP_DB < 1) begin : g_bad_cfg
      $error("drc_level_detector: bad threshold config");
   end

   logic signed [CW-1:0] c_cur  [NSTG];
   logic signed [CW-1:0] c_prev [NSTG];
   logic signed [CW-1:0] c_fb   [NSTG];
   logic signed [W-1:0]  st_in  [NSTG];
   logic signed [W-1:0]  st_out [NSTG];
   logic                 st_step[NSTG];
   logic                 lp_vld;
   logic                 dec_vld;
   logic signed [LVW-1:0] level_db;

   assign c_cur[0]  = hp_c0;
   assign c_prev[0] = hp_c1;
   assign c_fb[0]   = hp_fb;
   assign c_cur[1]  = lp_c0;
   assign c_prev[1] = lp_c1;
   assign c_fb[1]   = lp_fb;
   assign st_in[0]   = smp_in;
   assign st_step[0] = smp_vld;
   assign st_in[1]   = st_out[0];
   assign st_step[1] = lp_vld;

   for (genvar s = 0; s < NSTG; s++) begin : g_stg
      drc_iir1 #(.W(W), .CW(CW)) u_iir (
         .clk    (clk),
         .rst_n  (rst_n),
         .step   (st_step[s]),
         .x      (st_in[s]),
         .c_cur  (c_cur[s]),
         .c_prev (c_prev[s]),
         .c_fb   (c_fb[s]),
         .y      (st_out[s])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lp_vld  <= 1'b0;
         dec_vld <= 1'b0;
      end else begin
         lp_vld  <= smp_vld;
         dec_vld <= lp_vld;
      end
   end

   drc_log_level #(.W(W), .LVW(LVW)) u_log (
      .val   (st_out[NSTG-1]),
      .level (level_db)
   );

   drc_hyst_decide #(.TW(TW), .HW(HW), .LVW(LVW), .STEP_DB(STEP_DB)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd       (dec_vld),
      .en        (det_en),
      .level     (level_db),
      .thr_code  (thr_code),
      .hyst_code (hyst_code),
      .rd        (flag_rd),
      .active    (comp_active),
      .live      (over_live),
      .sticky    (over_sticky)
   );
endmodule

// File: rtl/drc_level_detector_chk.sv
module drc_level_detector_chk (
   input logic clk,
   input logic rst_n,
   input logic det_en,
   input logic flag_rd,
   input logic dec_vld,
   input logic comp_active,
   input logic over_live,
   input logic over_sticky
);
   a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
      over_sticky && !flag_rd |=> over_sticky);

   a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_vld && flag_rd |=> !over_sticky);

   a_r7_live_sets_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(over_live) |-> over_sticky);

   a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      dec_vld && !det_en |=> !comp_active && !over_live);

   a_r10_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_vld |=> $stable(comp_active) && $stable(over_live));

   a_r5_on_needs_over: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(comp_active) |-> over_live);
endmodule

bind drc_level_detector drc_level_detector_chk u_chk (.*);

// File: tb/drc_level_detector_bench.sv
`timescale 1ns/1ps
module drc_level_detector_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic smp_vld = 1'b0;
   logic signed [15:0] smp_in = '0;
   logic signed [15:0] hp_c0 = '0, hp_c1 = '0, hp_fb = '0;
   logic signed [15:0] lp_c0 = '0, lp_c1 = '0, lp_fb = '0;
   logic det_en = 1'b0;
   logic [2:0] thr_code = '0;
   logic [1:0] hyst_code = '0;
   logic flag_rd = 1'b0;
   logic comp_active, over_live, over_sticky;

   int n_cmp = 0, n_bad = 0;
   int hxp = 0, hyp = 0, lxp = 0, lyp = 0;
   bit m_act = 0, m_live = 0, m_stk = 0;
   bit done = 0;

   always #4 clk = ~clk;

   drc_level_detector u_drc_level_detector (
      .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_in(smp_in),
      .hp_c0(hp_c0), .hp_c1(hp_c1), .hp_fb(hp_fb),
      .lp_c0(lp_c0), .lp_c1(lp_c1), .lp_fb(lp_fb),
      .det_en(det_en), .thr_code(thr_code), .hyst_code(hyst_code),
      .flag_rd(flag_rd), .comp_active(comp_active),
      .over_live(over_live), .over_sticky(over_sticky)
   );

   task automatic chk(input bit got, input bit exp, input string what);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b at %0t", what, got, exp, $time);
      end
   endtask

   function automatic int filt(input int c0, input int c1, input int fb,
                               input int x, input int xp, input int yp);
      longint acc = longint'(c0) * x + longint'(c1) * xp + longint'(fb) * yp;
      longint y = acc >>> 15;
      if (y > 32767) y = 32767;
      if (y < -32768) y = -32768;
      return int'(y);
   endfunction

   function automatic int lvl_of(input int y);
      int m = (y < 0) ? -y : y;
      int p = 0;
      int f;
      if (m == 0) return -96;
      for (int i = 0; i < 16; i++) if ((m >> i) & 1) p = i;
      f = ((m << (15 - p)) >> 12) & 7;
      return 6 * p + $rtoi(20.0 * $log10(1.0 + real'(f) / 8.0) + 0.5) - 90;
   endfunction

   task automatic send(input int x, input bit rd);
      int hn, ln, lv, thr, h;
      bit set;
      @(negedge clk); smp_vld = 1'b1; smp_in = x[15:0];
      @(negedge clk); smp_vld = 1'b0;
      chk(comp_active, m_act, "R10 active held after first edge");
      @(negedge clk); flag_rd = rd;
      chk(over_live, m_live, "R10 live held after second edge");
      @(negedge clk); flag_rd = 1'b0;
      hn = filt(int'(hp_c0), int'(hp_c1), int'(hp_fb), x, hxp, hyp);
      hxp = x; hyp = hn;
      ln = filt(int'(lp_c0), int'(lp_c1), int'(lp_fb), hn, lxp, lyp);
      lxp = hn; lyp = ln;
      lv = lvl_of(ln);
      thr = -3 * (int'(thr_code) + 1);
      h = int'(hyst_code);
      set = 0;
      if (!det_en) begin
         m_act = 0; m_live = 0;
      end else begin
         m_live = lv > thr; set = m_live;
         if (m_act) begin if (lv < thr - h) m_act = 0; end
         else if (lv > thr + h) m_act = 1;
      end
      m_stk = set | (m_stk & ~rd);
      chk(comp_active, m_act, det_en ? "R2 R3 R4 R5 R6 active" : "R9 active");
      chk(over_live, m_live, det_en ? "R2 R3 R7 live" : "R9 live");
      chk(over_sticky, m_stk, "R8 sticky");
   endtask

   task automatic host_read();
      @(negedge clk); flag_rd = 1'b1;
      @(negedge clk); flag_rd = 1'b0;
      m_stk = 0;
      chk(over_sticky, 1'b0, "R8 read clears");
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_bad++; n_cmp++;
         $display("FAIL watchdog: got hang expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] lf;
      int amp;
      repeat (3) @(negedge clk);
      chk(comp_active, 1'b0, "R1 active reset");
      chk(over_live, 1'b0, "R1 live reset");
      chk(over_sticky, 1'b0, "R1 sticky reset");
      rst_n = 1'b1;
      det_en = 1'b1;
      hp_c0 = 16'sh7fff; lp_c0 = 16'sh7fff;

      // sweep every threshold and hysteresis code with 1 dB ramps
      for (int t = 0; t < 8; t++) begin
         for (int h = 0; h < 4; h++) begin
            thr_code = t[2:0]; hyst_code = h[1:0];
            for (int k = 0; k < 62; k++) begin
               int d = (k < 31) ? 30 - k : k - 31;
               amp = $rtoi(32767.0 * (10.0 ** (-real'(d) / 20.0)));
               send((k % 2) ? -amp : amp, 1'b0);
            end
            send(0, 1'b0);
            host_read();
         end
      end

      // R8: read on the same edge as a setting decision keeps the flag
      thr_code = 3'd3; hyst_code = 2'd0;
      send(30000, 1'b1);
      chk(over_sticky, 1'b1, "R8 read coincident with set");
      send(0, 1'b1);
      chk(over_sticky, 1'b0, "R8 read with quiet decision");

      // R9: disabled detector stays quiet on loud input
      send(30000, 1'b0);
      host_read();
      det_en = 1'b0;
      send(32000, 1'b0);
      send(-32000, 1'b0);
      chk(over_sticky, 1'b0, "R9 sticky not set while disabled");
      det_en = 1'b1;

      // real IIR coefficients, pseudo-random samples and controls
      hp_c0 = 16'sh7800; hp_c1 = -16'sh7800; hp_fb = 16'sh7000;
      lp_c0 = 16'sh2000; lp_c1 = 16'sh2000; lp_fb = 16'sh6000;
      lf = 16'hace1;
      for (int n = 0; n < 400; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         if (n % 50 == 0) begin
            thr_code = lf[2:0]; hyst_code = lf[4:3];
         end
         det_en = (n % 97) > 5;
         send(int'($signed(lf)), lf[7] & lf[2]);
      end
      // saturation case on both stages
      hp_c0 = 16'sh7fff; hp_c1 = 16'sh7fff; hp_fb = 16'sh7fff;
      for (int n = 0; n < 6; n++) send(-32768, 1'b0);

      done = 1;
      summary();
      $finish;
   end
endmodule